// File: doc/BRIEF.md
# Device Select Claim Monitor

This block sits on the initiator side of a parallel shared bus. It watches the active-low device select line after each address phase and reports whether a target claims the access, and on which decode clock. A claim on the first, second or third clock after the address phase is reported as fast, medium or slow. A claim on the fourth clock is reported as subtractive, because a subtractive decoding agent answers only at that last point. If nothing claims the access by the end of that fourth clock, the block raises a single-clock master abort pulse. The bus sequencer uses this pulse to end the transaction.

Special cycles are broadcast and expect no target to answer. When the command latched in the address phase is the special cycle code, the block never raises an abort. It samples only the start-of-frame strobe, the command code and device select, so it can be placed next to any initiator. It does not decode targets and it does not move data.

Top module: `dsel_monitor`

## Requirements
- R1: After reset, claim_o and master_abort_o are low and claim_speed_o is 0.
- R2: When frame_start_i is sampled high, a decode window opens, and the next clock is decode clock 1. If devsel_ni is sampled low in decode clock k (k = 1..4), claim_o is high for one cycle in the cycle after clock k. claim_speed_o then shows k-1: 0 fast, 1 medium, 2 slow, 3 subtractive.
- R3: If devsel_ni stays high through decode clock 4 and the latched command is not the special cycle, master_abort_o is high for exactly one cycle, in the cycle after decode clock 4.
- R4: The command is latched only when frame_start_i is sampled high. If the latched command is 4'b0001 (special cycle), master_abort_o never asserts for that window. Changes on cmd_i outside the address phase have no effect.
- R5: Only the first low sample of devsel_ni in a window counts, and it closes the window. devsel_ni low after the window closes, or while no window is open, produces no claim_o.
- R6: claim_speed_o keeps its value until the next claim.
- R7: frame_start_i sampled high while a window is open restarts the count at decode clock 1 and latches the new command.
- R8: devsel_ni is still evaluated for the open window in the same clock where a new frame_start_i is sampled. If that is decode clock 4 with no claim, the abort for the old window is reported while the new window starts.
- R9: claim_o and master_abort_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | High for the address phase clock of a new access |
| cmd_i | input | 4 | Bus command, sampled with frame_start_i |
| devsel_ni | input | 1 | Active-low device select from the bus |
| claim_o | output | 1 | One-cycle pulse: the access was claimed |
| claim_speed_o | output | 2 | Decode clock of the last claim, minus one |
| master_abort_o | output | 1 | One-cycle pulse: no target claimed the access |

## Verification
The end of one window and the start of the next can fall on the same clock edge. This happens when a new address phase is driven in decode clock 4 of a window that nobody has claimed. The bench provokes this case and expects two things: the abort pulse for the old window in the next cycle, and a decode-clock-1 claim for the new window on the clock after that. This shows the restart did not suppress the old verdict and the old verdict did not block the new window. A restart earlier in a window uses a special cycle command. No abort may then appear at the point where the abandoned window would have timed out.

// File: rtl/dsel_pkg.sv
package dsel_pkg;
  localparam int unsigned CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_SPECIAL = 4'b0001;
  typedef logic [CMD_W-1:0] cmd_t;
endpackage

// File: rtl/dsel_cmd_latch.sv
module dsel_cmd_latch
  import dsel_pkg::*;
#(
  parameter cmd_t SPECIAL_CODE = CMD_SPECIAL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  cmd_t cmd_i,
  output logic special_o
);
  logic special_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            special_q <= 1'b0;
    else if (frame_start_i) special_q <= (cmd_i == SPECIAL_CODE);
  end

  assign special_o = special_q;
endmodule

// File: rtl/dsel_window_ctr.sv
module dsel_window_ctr #(
  parameter int unsigned WINDOW = 4,
  localparam int unsigned CNT_W = $clog2(WINDOW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             hit_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign last_o = active_q && (cnt_q == CNT_W'(WINDOW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (frame_start_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(1);
    end else if (active_q && (hit_i || last_o)) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(WINDOW)));
endmodule

// File: rtl/dsel_claim_eval.sv
module dsel_claim_eval #(
  parameter int unsigned WINDOW = 4,
  localparam int unsigned CNT_W   = $clog2(WINDOW + 1),
  localparam int unsigned SPEED_W = $clog2(WINDOW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  logic               last_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               special_i,
  input  logic               devsel_ni,
  output logic               hit_o,
  output logic               claim_o,
  output logic [SPEED_W-1:0] speed_o,
  output logic               abort_o
);
  logic               claim_q, abort_q;
  logic [SPEED_W-1:0] speed_q;

  assign hit_o = active_i && !devsel_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claim_q <= 1'b0;
      abort_q <= 1'b0;
      speed_q <= '0;
    end else begin
      claim_q <= hit_o;
      abort_q <= last_i && !hit_o && !special_i;
      if (hit_o) speed_q <= SPEED_W'(cnt_i - 1'b1);
    end
  end

  assign claim_o = claim_q;
  assign abort_o = abort_q;
  assign speed_o = speed_q;

  assert_speed_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !claim_q |=> (claim_q || $stable(speed_q)));
endmodule

// File: rtl/dsel_monitor.sv
module dsel_monitor
  import dsel_pkg::*;
#(
  parameter int unsigned WINDOW = 4,
  localparam int unsigned CNT_W   = $clog2(WINDOW + 1),
  localparam int unsigned SPEED_W = $clog2(WINDOW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               devsel_ni,
  output logic               claim_o,
  output logic [SPEED_W-1:0] claim_speed_o,
  output logic               master_abort_o
);
  logic             special, active, last, hit;
  logic [CNT_W-1:0] cnt;

  dsel_cmd_latch #(.SPECIAL_CODE(CMD_SPECIAL)) u_cmd (
    .clk_i, .rst_ni, .frame_start_i, .cmd_i, .special_o(special)
  );

  dsel_window_ctr #(.WINDOW(WINDOW)) u_win (
    .clk_i, .rst_ni, .frame_start_i, .hit_i(hit),
    .active_o(active), .cnt_o(cnt), .last_o(last)
  );

  dsel_claim_eval #(.WINDOW(WINDOW)) u_eval (
    .clk_i, .rst_ni, .active_i(active), .last_i(last), .cnt_i(cnt),
    .special_i(special), .devsel_ni, .hit_o(hit),
    .claim_o, .speed_o(claim_speed_o), .abort_o(master_abort_o)
  );

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(claim_o && master_abort_o));
  assert_abort_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_abort_o |=> !master_abort_o);
  assert_special_no_abort_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(master_abort_o) |-> !$past(special));
  assert_claim_in_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(claim_o) |-> $past(active));
endmodule

// File: tb/dsel_monitor_tb.sv
module dsel_monitor_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_start_i = 1'b0;
  logic [3:0] cmd_i = 4'h0;
  logic       devsel_ni = 1'b1;
  logic       claim_o, master_abort_o;
  logic [1:0] claim_speed_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dsel_monitor u_dut (
    .clk_i, .rst_ni, .frame_start_i, .cmd_i, .devsel_ni,
    .claim_o, .claim_speed_o, .master_abort_o
  );

  typedef struct packed {
    logic [3:0] cmd;
    logic [2:0] claim_clk; // 0 = no claim
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'h6, 3'd1}, '{4'h7, 3'd2}, '{4'h6, 3'd3}, '{4'h7, 3'd4},
    '{4'h6, 3'd0}, '{4'h1, 3'd0}, '{4'h1, 3'd2}, '{4'hA, 3'd0},
    '{4'h0, 3'd4}, '{4'h2, 3'd1}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      finish_run();
    end
  end

  task automatic start_frame(input logic [3:0] cmd);
    frame_start_i = 1'b1; cmd_i = cmd; devsel_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    frame_start_i = 1'b0; cmd_i = 4'hF;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 claim", {3'b0, claim_o}, 4'h0);
    chk("R1 abort", {3'b0, master_abort_o}, 4'h0);
    chk("R1 speed", {2'b0, claim_speed_o}, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4 table walk
    foreach (VECS[i]) begin
      start_frame(VECS[i].cmd);
      for (int c = 1; c <= 4; c++) begin
        devsel_ni = (c == VECS[i].claim_clk) ? 1'b0 : 1'b1;
        @(posedge clk_i); @(negedge clk_i);
        chk("R2 claim", {3'b0, claim_o}, {3'b0, c == VECS[i].claim_clk});
        if (c == VECS[i].claim_clk)
          chk("R2 speed", {2'b0, claim_speed_o}, 4'(c - 1));
        chk("R3/R4 abort", {3'b0, master_abort_o},
            {3'b0, (c == 4) && (VECS[i].claim_clk == 0) && (VECS[i].cmd != 4'h1)});
      end
      devsel_ni = 1'b1;
      @(negedge clk_i);
      chk("R3 abort one cycle", {3'b0, master_abort_o}, 4'h0);
    end

    // R5: idle devsel low, then held low across a window
    devsel_ni = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      chk("R5 idle no claim", {3'b0, claim_o}, 4'h0);
    end
    devsel_ni = 1'b1;
    start_frame(4'h6);
    devsel_ni = 1'b1; @(negedge clk_i);
    devsel_ni = 1'b0; @(negedge clk_i);
    chk("R5 first claim", {3'b0, claim_o}, 4'h1);
    chk("R2 medium", {2'b0, claim_speed_o}, 4'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk("R5 no second claim", {3'b0, claim_o}, 4'h0);
      chk("R6 speed held", {2'b0, claim_speed_o}, 4'h1);
      chk("R5 no abort", {3'b0, master_abort_o}, 4'h0);
    end
    devsel_ni = 1'b1;

    // R7: restart in clock 2 with special cycle, R4 cmd_i changes ignored
    start_frame(4'h6);
    @(negedge clk_i);
    frame_start_i = 1'b1; cmd_i = 4'h1;
    @(negedge clk_i);
    frame_start_i = 1'b0; cmd_i = 4'h6;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      chk("R7 restarted special no abort", {3'b0, master_abort_o}, 4'h0);
    end

    // R8: new frame in clock 4 of unclaimed window
    start_frame(4'h6);
    repeat (3) @(negedge clk_i);
    frame_start_i = 1'b1; cmd_i = 4'h7;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    chk("R8 old abort", {3'b0, master_abort_o}, 4'h1);
    chk("R9 no claim with abort", {3'b0, claim_o}, 4'h0);
    devsel_ni = 1'b0;
    @(negedge clk_i);
    devsel_ni = 1'b1;
    chk("R8 new window claim", {3'b0, claim_o}, 4'h1);
    chk("R8 new window fast", {2'b0, claim_speed_o}, 4'h0);
    chk("R8 abort ended", {3'b0, master_abort_o}, 4'h0);

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule